// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block holds the interrupt state of a UART. It watches the fill counts of the receive and transmit FIFOs and compares them against two programmable trigger levels. From that comparison it produces a live status word with empty, full and at-or-above-trigger flags for each direction. On every clock the live FIFO flags are folded into a sticky interrupt status word, together with one-cycle event pulses for overflow, framing, parity, receive timeout and modem-change conditions. Software clears the sticky word by writing ones to the bits it wants cleared.

The mask is not written directly. One register address sets mask bits and another clears them. A write to the mask's own address has no effect. The single interrupt output is a level that stays high while any sticky bit is also enabled in the mask. Reads are combinational and select one register by address. Writes take effect at the next rising clock edge.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live word at read address 6 has these bits: bit0 = rx_count >= RX trigger, bit1 = rx_count == 0, bit2 = rx_count == DEPTH, bit3 = tx_count == 0, bit4 = tx_count == DEPTH, bit13 = tx_count >= TX trigger. All other bits read 0.
- R2: At every rising edge, live bits 4..0 are ORed into sticky bits 4..0 at the same positions. Live bit13 sets sticky bit10, and sticky bit13 stays 0.
- R3: A one-cycle event pulse sets its sticky bit at the next edge: rx overflow bit5, framing bit6, parity bit7, rx timeout bit8, modem change bit9, tx overflow bit12.
- R4: A write to address 3 (sticky status) clears every sticky bit written as 1 and leaves the others. If a set source for the same bit is active in that cycle, the bit ends up set.
- R5: A write to address 0 (enable) ORs the written data into the mask.
- R6: A write to address 1 (disable) clears from the mask every bit written as 1.
- R7: A write to address 2 (mask) leaves the mask unchanged. The mask reads back at address 2.
- R8: irq is high exactly when (mask AND sticky) is non-zero, and it follows register updates with no extra delay by default.
- R9: While reset is held, mask and sticky read 0, irq is 0, and both trigger levels read 32.
- R10: Addresses 4 (RX trigger) and 5 (TX trigger) are writable and read back. The live compares in R1 use the written values.
- R11: Sticky bits 11, 13, 14 and 15 are never set, so enabling them in the mask never raises irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read register select |
| rd_data | output | DATA_W | Combinational read data |
| rx_count | input | CNT_W | Receive FIFO fill count |
| tx_count | input | CNT_W | Transmit FIFO fill count |
| ev_rx_ovf | input | 1 | Receive overflow pulse |
| ev_frame_err | input | 1 | Framing error pulse |
| ev_parity_err | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem_chg | input | 1 | Modem status change pulse |
| ev_tx_ovf | input | 1 | Transmit overflow pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions can act on the same sticky bit in one cycle: software's write-one-to-clear, and a set from either a live FIFO flag or an event pulse. The bench provokes this in two ways. First, it writes all ones to the status register while the FIFO counts hold a pattern, and expects exactly the mapped live flags to remain. Second, it pulses the transmit overflow input in the same cycle as a clear of bit12 and expects bit12 to stay set. A later clear, with no pulse, must remove the bit.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [2:0] {
      REG_IRQ_EN   = 3'd0,
      REG_IRQ_DIS  = 3'd1,
      REG_IRQ_MASK = 3'd2,
      REG_IRQ_STAT = 3'd3,
      REG_RX_LVL   = 3'd4,
      REG_TX_LVL   = 3'd5,
      REG_LIVE     = 3'd6
   } reg_sel_e;

   // live status positions
   localparam int LIVE_RX_TRIG  = 0;
   localparam int LIVE_RX_EMPTY = 1;
   localparam int LIVE_RX_FULL  = 2;
   localparam int LIVE_TX_EMPTY = 3;
   localparam int LIVE_TX_FULL  = 4;
   localparam int LIVE_TX_TRIG  = 13;

   // sticky status positions
   localparam int IRQ_RX_OVF   = 5;
   localparam int IRQ_FRAME    = 6;
   localparam int IRQ_PARITY   = 7;
   localparam int IRQ_TIMEOUT  = 8;
   localparam int IRQ_MODEM    = 9;
   localparam int IRQ_TX_TRIG  = 10;
   localparam int IRQ_TX_OVF   = 12;

   localparam logic [15:0] IRQ_IMPL = 16'h17FF;

endpackage

// File: rtl/uirq_level_flags.sv
module uirq_level_flags
   import uart_irq_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int CNT_W  = 7,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [CNT_W-1:0]  rx_lvl,
   input  logic [CNT_W-1:0]  tx_lvl,
   output logic [DATA_W-1:0] live
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   always_comb begin
      live                = '0;
      live[LIVE_RX_TRIG]  = (rx_count >= rx_lvl);
      live[LIVE_RX_EMPTY] = (rx_count == '0);
      live[LIVE_RX_FULL]  = (rx_count == DEPTH_C);
      live[LIVE_TX_EMPTY] = (tx_count == '0);
      live[LIVE_TX_FULL]  = (tx_count == DEPTH_C);
      live[LIVE_TX_TRIG]  = (tx_count >= tx_lvl);
   end

   // R1
   rx_empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(live[LIVE_RX_EMPTY] && live[LIVE_RX_FULL]));

   // R1
   tx_empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(live[LIVE_TX_EMPTY] && live[LIVE_TX_FULL]));

endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
   import uart_irq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] mask_q
);

   logic set_hit;
   logic clr_hit;

   assign set_hit = wr_en && (wr_addr == ADDR_W'(REG_IRQ_EN));
   assign clr_hit = wr_en && (wr_addr == ADDR_W'(REG_IRQ_DIS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (set_hit) begin
         mask_q <= mask_q | wr_data;
      end else if (clr_hit) begin
         mask_q <= mask_q & ~wr_data;
      end
   end

   // R5
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

   // R6
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> ((mask_q & $past(wr_data)) == '0));

   // R7
   mask_direct_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(REG_IRQ_MASK)) |=> $stable(mask_q));

endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
   parameter int                DATA_W = 16,
   parameter logic [DATA_W-1:0] IMPL   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] stat_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= ((stat_q & ~clr_vec) | set_vec) & IMPL;
      end
   end

   // R4 set wins over a coincident clear
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(set_vec & IMPL)) == $past(set_vec & IMPL)));

   // R4
   clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0));

   // R11
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & ~IMPL) == '0));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int TRIG_RST    = 32,
   parameter bit IRQ_REG_OUT = 1'b0,
   localparam int CNT_W      = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              ev_rx_ovf,
   input  logic              ev_frame_err,
   input  logic              ev_parity_err,
   input  logic              ev_rx_timeout,
   input  logic              ev_modem_chg,
   input  logic              ev_tx_ovf,
   output logic              irq
);

   localparam logic [DATA_W-1:0] IMPL_W   = DATA_W'(IRQ_IMPL);
   localparam logic [CNT_W-1:0]  TRIG_INI = CNT_W'(TRIG_RST);

   if (DATA_W < 14) begin : g_bad_width
      $error("DATA_W must hold bit 13");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end
   if (DEPTH < 2 || TRIG_RST > DEPTH) begin : g_bad_depth
      $error("DEPTH too small or TRIG_RST above DEPTH");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("count width exceeds data width");
   end

   logic [CNT_W-1:0]  rx_lvl_q;
   logic [CNT_W-1:0]  tx_lvl_q;
   logic [DATA_W-1:0] live;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_vec;
   logic              irq_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lvl_q <= TRIG_INI;
         tx_lvl_q <= TRIG_INI;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(REG_RX_LVL)) rx_lvl_q <= wr_data[CNT_W-1:0];
         if (wr_addr == ADDR_W'(REG_TX_LVL)) tx_lvl_q <= wr_data[CNT_W-1:0];
      end
   end

   uirq_level_flags #(
      .DEPTH (DEPTH),
      .CNT_W (CNT_W),
      .DATA_W(DATA_W)
   ) i_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_count(rx_count),
      .tx_count(tx_count),
      .rx_lvl  (rx_lvl_q),
      .tx_lvl  (tx_lvl_q),
      .live    (live)
   );

   uirq_mask_reg #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W)
   ) i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .mask_q (mask_q)
   );

   always_comb begin
      set_vec              = '0;
      set_vec[4:0]         = live[4:0];
      set_vec[IRQ_TX_TRIG] = live[LIVE_TX_TRIG];
      set_vec[IRQ_RX_OVF]  = ev_rx_ovf;
      set_vec[IRQ_FRAME]   = ev_frame_err;
      set_vec[IRQ_PARITY]  = ev_parity_err;
      set_vec[IRQ_TIMEOUT] = ev_rx_timeout;
      set_vec[IRQ_MODEM]   = ev_modem_chg;
      set_vec[IRQ_TX_OVF]  = ev_tx_ovf;
   end

   assign clr_vec = (wr_en && wr_addr == ADDR_W'(REG_IRQ_STAT)) ? wr_data : '0;

   uirq_sticky #(
      .DATA_W(DATA_W),
      .IMPL  (IMPL_W)
   ) i_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec(set_vec),
      .clr_vec(clr_vec),
      .stat_q (stat_q)
   );

   assign irq_raw = |(mask_q & stat_q);

   if (IRQ_REG_OUT) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= irq_raw;
      end
   end else begin : g_irq_comb
      assign irq = irq_raw;
      // R8
      irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> ((stat_q != '0) && (mask_q != '0)));
   end

   always_comb begin
      case (rd_addr)
         ADDR_W'(REG_IRQ_MASK): rd_data = mask_q;
         ADDR_W'(REG_IRQ_STAT): rd_data = stat_q;
         ADDR_W'(REG_RX_LVL):   rd_data = DATA_W'(rx_lvl_q);
         ADDR_W'(REG_TX_LVL):   rd_data = DATA_W'(tx_lvl_q);
         ADDR_W'(REG_LIVE):     rd_data = live;
         default:               rd_data = '0;
      endcase
   end

   // R2
   tx_trig_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live[LIVE_TX_TRIG] |=> stat_q[IRQ_TX_TRIG]);

endmodule

// File: tb/test_uart_irq_ctrl.sv
module test_uart_irq_ctrl;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic [6:0]  rx_count = '0;
   logic [6:0]  tx_count = '0;
   logic [5:0]  ev = '0;
   logic        irq;

   int errors = 0;
   int checks = 0;

   always #(CLK_P/2) clk = ~clk;

   uart_irq_ctrl i_uart_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .rx_count(rx_count), .tx_count(tx_count),
      .ev_rx_ovf(ev[0]), .ev_frame_err(ev[1]), .ev_parity_err(ev[2]),
      .ev_rx_timeout(ev[3]), .ev_modem_chg(ev[4]), .ev_tx_ovf(ev[5]),
      .irq(irq));

   // {rx_count, tx_count, expected live}
   localparam logic [29:0] VEC [0:7] = '{
      {7'd0,  7'd0,  16'h000A},
      {7'd31, 7'd5,  16'h0000},
      {7'd32, 7'd0,  16'h0009},
      {7'd64, 7'd31, 16'h0005},
      {7'd10, 7'd32, 16'h2000},
      {7'd1,  7'd64, 16'h2010},
      {7'd63, 7'd33, 16'h2001},
      {7'd64, 7'd64, 16'h2015}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulse(input logic [5:0] p);
      @(negedge clk);
      ev = p;
      @(negedge clk);
      ev = '0;
   endtask

   initial begin
      #(CLK_P * 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] d;
      // reset state
      #(CLK_P * 3);
      rd(3'd2, d); chk("R9 mask", d, 16'h0000);
      rd(3'd3, d); chk("R9 sticky", d, 16'h0000);
      rd(3'd4, d); chk("R9 rx trig", d, 16'd32);
      rd(3'd5, d); chk("R9 tx trig", d, 16'd32);
      chk("R9 irq", {15'b0, irq}, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // table walk: live word and sticky after clear-with-set
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rx_count = VEC[i][29:23];
         tx_count = VEC[i][22:16];
         wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hFFFF;
         @(negedge clk);
         wr_en = 1'b0;
         rd(3'd6, d); chk("R1 live", d, VEC[i][15:0]);
         rd(3'd3, d);
         chk("R2 R4 sticky", d, {5'b0, VEC[i][13], 5'b0, VEC[i][4:0]});
      end

      // quiet counts and clear
      @(negedge clk); rx_count = 7'd5; tx_count = 7'd5;
      wr(3'd3, 16'hFFFF);
      rd(3'd3, d); chk("R4 clear all", d, 16'h0000);

      // mask manipulation
      wr(3'd0, 16'h0003); rd(3'd2, d); chk("R5 enable", d, 16'h0003);
      wr(3'd0, 16'h0100); rd(3'd2, d); chk("R5 enable or", d, 16'h0103);
      wr(3'd2, 16'hFFFF); rd(3'd2, d); chk("R7 mask write ignored", d, 16'h0103);
      wr(3'd1, 16'h0001); rd(3'd2, d); chk("R6 disable", d, 16'h0102);

      // irq level
      #1 chk("R8 irq idle", {15'b0, irq}, 16'h0000);
      pulse(6'b001000);
      rd(3'd3, d); chk("R3 timeout", d, 16'h0100);
      chk("R8 irq timeout", {15'b0, irq}, 16'h0001);
      wr(3'd3, 16'h0100);
      #1 chk("R8 irq cleared", {15'b0, irq}, 16'h0000);
      @(negedge clk); rx_count = 7'd0;
      @(negedge clk); #1 chk("R8 irq rx empty", {15'b0, irq}, 16'h0001);
      rx_count = 7'd5;
      wr(3'd3, 16'hFFFF);
      #1 chk("R8 irq low again", {15'b0, irq}, 16'h0000);

      // all events with mask off
      wr(3'd1, 16'hFFFF);
      pulse(6'b111111);
      rd(3'd3, d); chk("R3 all events", d, 16'h13E0);
      chk("R8 irq masked", {15'b0, irq}, 16'h0000);
      wr(3'd0, 16'h0800);
      #1 chk("R11 reserved bit irq", {15'b0, irq}, 16'h0000);
      rd(3'd3, d); chk("R11 reserved zero", d & 16'hE800, 16'h0000);

      // partial clear and coincident set
      wr(3'd3, 16'h0020); rd(3'd3, d); chk("R4 partial clear", d, 16'h13C0);
      @(negedge clk);
      ev = 6'b100000; wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'h1000;
      @(negedge clk);
      ev = '0; wr_en = 1'b0;
      rd(3'd3, d); chk("R4 set wins", d, 16'h13C0);
      wr(3'd3, 16'h1000); rd(3'd3, d); chk("R4 clear after", d, 16'h03C0);

      // trigger levels
      wr(3'd4, 16'd5); rd(3'd4, d); chk("R10 rx trig read", d, 16'd5);
      rd(3'd6, d); chk("R10 rx at trig", d, 16'h0001);
      rx_count = 7'd4;
      rd(3'd6, d); chk("R10 rx below trig", d, 16'h0000);
      wr(3'd5, 16'd0); rd(3'd5, d); chk("R10 tx trig read", d, 16'd0);
      rd(3'd6, d); chk("R10 tx trig zero", d, 16'h2000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule